// File: doc/BRIEF.md
# Instruction Cache Control Register with Invalidation Sequencer

This block is the software-visible control word for an instruction cache and the stream buffers that prefetch ahead of it. Software writes a single register to turn the cache on or off, request a full flush, keep the cache coherent with flash programming, choose which prefetch buffer runs in the reduced modes, and arm a one-time parity fault for testing the integrity path.

Behind the register, a small sequencer gathers every reason to flush the cache into one request/acknowledge handshake with the cache arrays. These reasons are a manual request, a change of the enable bit, and a flash programming event while coherency is on. A reason that arrives during a flush in progress is held, and it starts a second round once the first completes. The block also drives the prefetch mode and buffer choice. It emits a one-cycle pulse that tells the cache to drop the line being accessed and tells the system that an integrity error happened.

Top module: `cache_ctl_regs`

## Requirements
- R1: Writing 1 to bit 11 (manual flush) raises `inv_req` on the next cycle. Bit 11 reads 1 until a flush round completes with nothing further queued, and then reads 0.
- R2: The completion of any flush round clears bit 11, including rounds started automatically after reset, by the enable bit or by flash programming.
- R3: A write that changes bit 15 (enable), in either direction, starts a flush whether `pause` is high or low.
- R4: While bit 10 (coherency) is 1, a pulse on `flash_prog` starts a flush. While it is 0, `flash_prog` starts nothing.
- R5: `pf_basic` is 1 exactly when bit 15 is 0. This selects the single-slice, two-entry prefetch mode.
- R6: `pf_sel_active` is 1 when bit 15 is 0 or `pause` is 1. `pf_buf_idx` is then 0 when bit 16 is 1 and 1 when bit 16 is 0.
- R7: If a write clears bit 15 in the same cycle that `pause` rises, the block ends up in the disabled mode (`pf_basic` = 1) and a flush is requested.
- R8: Bit 0 set arms one fault. The next cycle with `cache_access` high gives a one-cycle pulse on `integ_evt` and on `line_flush` in the following cycle and clears bit 0. Later accesses give no pulse until bit 0 is written 1 again.
- R9: After reset the register reads 0x0000_8C01: bits 15, 11, 10 and 0 are 1, bit 16 is 0, and all other bits are 0.
- R10: `inv_req` stays high until `inv_done` is sampled high. A trigger that arrives while `inv_req` is high causes one more round after the current one ends.
- R11: Writing 0 to bit 11 or bit 0 has no effect. Only hardware clears these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current register contents |
| pause | input | 1 | Cache pause state |
| flash_prog | input | 1 | Flash programming event pulse |
| inv_req | output | 1 | Full flush request to cache and buffers |
| inv_done | input | 1 | Flush completion pulse |
| cache_access | input | 1 | A cache access takes place this cycle |
| pf_basic | output | 1 | Single-slice prefetch mode |
| pf_sel_active | output | 1 | Buffer selection is in force |
| pf_buf_idx | output | 1 | Selected prefetch buffer |
| integ_evt | output | 1 | Integrity error event pulse |
| line_flush | output | 1 | Drop the accessed line |

## Verification
Some properties are checked on every cycle. The request is held until `inv_done`. An enable change always leads to a request. Flash events do nothing while coherency is off. Bit 11 only falls after a completion. A disarmed fault bit stays disarmed unless software writes 1. The disable-with-pause priority is checked too. Other behaviour needs the bench's scenarios: queued rounds merging after a completion, the exact reset word, buffer index decoding across enable and pause states, and a fault pulse appearing once per arming in the expected cycle, which the scoreboard matches against queued expectations.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
   // Bit positions software relies on
   localparam int B_INJ = 0;
   localparam int B_COH = 10;
   localparam int B_MAN = 11;
   localparam int B_EN  = 15;
   localparam int B_SEL = 16;
   localparam int B_TOP = B_SEL;
endpackage

// File: rtl/ccr_inval_seq.sv
module ccr_inval_seq #(
   parameter bit RESET_PEND = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic done,
   output logic req,
   output logic pend,
   output logic cmpl
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req  <= 1'b0;
         pend <= RESET_PEND;
      end else if (req) begin
         if (done) req <= 1'b0;
         pend <= pend | trig;
      end else if (pend | trig) begin
         req  <= 1'b1;
         pend <= 1'b0;
      end
   end

   // A round finishes with nothing left queued
   assign cmpl = req & done & ~pend & ~trig;

   // R10: request is held until completion
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req && !done |=> req);
   // R10: a trigger during a round is not lost
   p_merge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req && trig |=> (req || pend));
endmodule

// File: rtl/ccr_fault_inj.sv
module ccr_fault_inj #(
   parameter bit EVT_REG = 1'b1,
   parameter bit ARM_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_set,
   input  logic access,
   output logic armed,
   output logic evt
);
   logic fire;
   assign fire = armed & access;

   always_ff @(posedge clk) begin
      if (!rst_n)       armed <= ARM_RST;
      else if (arm_set) armed <= 1'b1;
      else if (fire)    armed <= 1'b0;
   end

   generate
      if (EVT_REG) begin : g_reg
         logic evt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) evt_q <= 1'b0;
            else        evt_q <= fire;
         end
         assign evt = evt_q;
         // R8: a pulse only follows an access
         p_evt_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
            evt |-> $past(access));
      end else begin : g_comb
         assign evt = fire;
      end
   endgenerate

   // R8: one access consumes the arming
   p_inj_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      access && armed && !arm_set |=> !armed);
endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
   import cache_ctl_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit EVT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              pause,
   input  logic              flash_prog,
   output logic              inv_req,
   input  logic              inv_done,
   input  logic              cache_access,
   output logic              pf_basic,
   output logic              pf_sel_active,
   output logic              pf_buf_idx,
   output logic              integ_evt,
   output logic              line_flush
);
   generate
      if (DATA_W <= B_TOP) begin : g_bad_width
         $error("cache_ctl_regs: DATA_W too small for control bits");
      end
   endgenerate

   logic en_q, coh_q, sel_q, man_q;
   logic toggle, man_set, trig, seq_pend, seq_cmpl, inj_armed, inj_evt;

   assign toggle  = wr_en & (wr_data[B_EN] != en_q);
   assign man_set = wr_en & wr_data[B_MAN];
   assign trig    = man_set | toggle | (flash_prog & coh_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b1;
         coh_q <= 1'b1;
         sel_q <= 1'b0;
         man_q <= 1'b1;
      end else begin
         if (wr_en) begin
            en_q  <= wr_data[B_EN];
            coh_q <= wr_data[B_COH];
            sel_q <= wr_data[B_SEL];
         end
         if (man_set)       man_q <= 1'b1;
         else if (seq_cmpl) man_q <= 1'b0;
      end
   end

   ccr_inval_seq #(.RESET_PEND(1'b1)) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (trig),
      .done (inv_done),
      .req  (inv_req),
      .pend (seq_pend),
      .cmpl (seq_cmpl)
   );

   ccr_fault_inj #(.EVT_REG(EVT_REG), .ARM_RST(1'b1)) u_inj (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_set(wr_en & wr_data[B_INJ]),
      .access (cache_access),
      .armed  (inj_armed),
      .evt    (inj_evt)
   );

   assign integ_evt  = inj_evt;
   assign line_flush = inj_evt;

   // Prefetch mode: disable wins over pause by construction of the mode terms
   assign pf_basic      = ~en_q;
   assign pf_sel_active = ~en_q | pause;
   assign pf_buf_idx    = pf_sel_active & ~sel_q;

   always_comb begin
      rd_data        = '0;
      rd_data[B_INJ] = inj_armed;
      rd_data[B_COH] = coh_q;
      rd_data[B_MAN] = man_q;
      rd_data[B_EN]  = en_q;
      rd_data[B_SEL] = sel_q;
   end

   logic unused_wr;
   assign unused_wr = ^wr_data;

   // R3: any enable change leads to a flush
   p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      toggle |=> (inv_req || $past(inv_req)));
   // R4: coherency off means flash events are ignored
   p_coh_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !inv_req && !seq_pend && flash_prog && !coh_q && !wr_en |=> !inv_req);
   // R2: manual bit only falls on a completion
   p_man_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(man_q) |-> $past(inv_done));
   // R11: a zero write cannot arm the fault
   p_sc_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_armed && !(wr_en && wr_data[B_INJ]) |=> !inj_armed);
   // R7: clearing enable lands in disabled mode even with pause
   p_dis_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_data[B_EN] |=> (pf_basic && pf_sel_active));
endmodule

// File: tb/sim_cache_ctl_regs.sv
module sim_cache_ctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        pause = 1'b0, flash_prog = 1'b0, inv_done = 1'b0, cache_access = 1'b0;
   logic        inv_req, pf_basic, pf_sel_active, pf_buf_idx, integ_evt, line_flush;
   int          checks = 0, errors = 0, cyc = 0;
   int          exp_q[$];
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cache_ctl_regs u0 (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d; step(1); wr_en = 1'b0;
   endtask

   task automatic done_pulse;
      inv_done = 1'b1; step(1); inv_done = 1'b0;
   endtask

   // Driver: an access while armed pushes the expected pulse cycle
   task automatic access(input bit expect_evt);
      if (expect_evt) exp_q.push_back(cyc + 1);
      cache_access = 1'b1; step(1); cache_access = 1'b0;
   endtask

   // Monitor: compares every pulse against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (line_flush !== integ_evt) check("R8 flush/event match", line_flush, integ_evt);
         if (integ_evt) begin
            if (exp_q.size() == 0) check("R8 unexpected pulse", 1, 0);
            else check("R8 pulse cycle", cyc, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      check("R9 reset word", rd_data, 32'h0000_8C01);
      check("R9 no request in reset", inv_req, 0);
      rst_n = 1'b1; step(1);
      check("R2 reset round requested", inv_req, 1);
      done_pulse();
      check("R2 reset round clears bit 11", rd_data, 32'h0000_8401);
      check("R10 request dropped", inv_req, 0);
      // R4 off
      wr(32'h0000_8001);
      flash_prog = 1'b1; step(1); flash_prog = 1'b0;
      check("R4 coherency off no flush", inv_req, 0);
      step(2);
      check("R4 coherency off still idle", inv_req, 0);
      // R4 on
      wr(32'h0000_8401);
      flash_prog = 1'b1; step(1); flash_prog = 1'b0;
      check("R4 coherency on flush", inv_req, 1);
      done_pulse();
      // R1 and R11 (bit 0 written 0)
      wr(32'h0000_8C00);
      check("R1 manual request", inv_req, 1);
      check("R11 bit 0 kept", rd_data, 32'h0000_8C01);
      step(3);
      check("R10 held without done", inv_req, 1);
      wr(32'h0000_8401);
      check("R11 bit 11 kept on zero write", rd_data[11], 1);
      done_pulse();
      check("R1 bit 11 cleared", rd_data, 32'h0000_8401);
      // R3 and R5
      wr(32'h0000_0401);
      check("R3 disable flush", inv_req, 1);
      check("R5 basic mode", pf_basic, 1);
      done_pulse();
      pause = 1'b1;
      wr(32'h0000_8401);
      check("R3 enable under pause flush", inv_req, 1);
      check("R5 full mode", pf_basic, 0);
      done_pulse(); pause = 1'b0;
      // R10 merge
      wr(32'h0000_8C01);
      flash_prog = 1'b1; step(1); flash_prog = 1'b0;
      done_pulse();
      check("R10 gap after first round", inv_req, 0);
      check("R10 bit 11 kept while queued", rd_data[11], 1);
      step(1);
      check("R10 second round", inv_req, 1);
      done_pulse();
      check("R10 bit 11 cleared after second", rd_data[11], 0);
      // R6
      wr(32'h0001_0401); done_pulse();
      check("R6 active when disabled", pf_sel_active, 1);
      check("R6 bit16=1 selects buffer 0", pf_buf_idx, 0);
      wr(32'h0000_0401);
      check("R6 bit16=0 selects buffer 1", pf_buf_idx, 1);
      wr(32'h0000_8401); done_pulse();
      check("R6 inactive when enabled", pf_sel_active, 0);
      pause = 1'b1; step(1);
      check("R6 active under pause", pf_sel_active, 1);
      check("R6 pause buffer 1", pf_buf_idx, 1);
      pause = 1'b0; step(1);
      // R7
      pause = 1'b1; wr(32'h0000_0401);
      check("R7 disable wins", pf_basic, 1);
      check("R7 flush requested", inv_req, 1);
      done_pulse(); pause = 1'b0;
      // R8
      access(1'b1);
      check("R8 event asserted", integ_evt, 1);
      check("R8 bit 0 cleared", rd_data[0], 0);
      step(1);
      check("R8 one-cycle pulse", integ_evt, 0);
      access(1'b0); step(1);
      wr(32'h0000_0401);
      access(1'b1); step(2);
      check("R8 scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule